// File: doc/BRIEF.md
# PWM Channel with Event Action Table

This block is one pulse-width modulation channel. Two cascaded clock dividers, each set to divide by a power of two, produce a count strobe. On each strobe a timebase counter steps upward from zero to a programmable period and then wraps back to zero. Two compare values, A and B, are compared against the counter. Software writes only a shadow copy of each compare value. The working copy takes the shadow value when the counter goes to zero.

Each of the two outputs has its own action table. The table holds a two-bit action for each of four counter events: the counter reaching zero, the counter reaching the period, a match on compare A, and a match on compare B. An action can leave the output alone, drive it low, drive it high or invert it. This covers edge-aligned waveforms of either polarity and half-rate square waves. A shared enable freezes the timebase, so several channels can be started on the same cycle. A clear input returns the counter to zero at any time.

Top module: `pwm_aq_channel`

## Requirements
- R1: After reset the counter, both outputs and both working compare values read 0.
- R2: With a divide ratio of 1, the counter steps by one on every enabled cycle up to `period` and then wraps to 0, so one PWM cycle lasts `period`+1 strobes.
- R3: The counter advances once every 2^(`pre_sel1`+`pre_sel2`) enabled clock cycles. Clearing the counter also restarts both divider stages.
- R4: A shadow write leaves the working compare value unchanged until the counter next becomes 0, either by wrapping or by a clear. The value then appears on `cmp_a_q` or `cmp_b_q`.
- R5: Each action table is 8 bits: bits [1:0] hold the zero event, [3:2] the period event, [5:4] the compare-A match and [7:6] the compare-B match. The codes are 0 = no change, 1 = drive low, 2 = drive high, 3 = invert.
- R6: The output changes on the clock edge that ends a count strobe at the event's counter value. With zero=high and compare-A=low, the output stays high for compare-A strobes of each PWM cycle. With period=low and compare-B=high, it stays high from the compare-B value up to the period.
- R7: An invert action on the zero event gives a square wave whose period is twice the PWM period.
- R8: When several events with actions other than "no change" occur together, zero beats period, period beats compare-A and compare-A beats compare-B. An event whose code is "no change" does not mask a lower-priority event.
- R9: A working compare value above `period` never produces a match.
- R10: While `cnt_en` is low, the counter, the dividers and both outputs hold their values. Outputs change only on strobes.
- R11: `cnt_clr` forces the counter to 0 on the next edge and loads both shadow values into the working compare values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Timebase run enable, shared between channels |
| cnt_clr | input | 1 | Clear the counter and dividers, load the shadow values |
| pre_sel1 | input | PRE_SEL_W | First divider stage, divide by 2^value |
| pre_sel2 | input | PRE_SEL_W | Second divider stage, divide by 2^value |
| period | input | CNT_W | Highest counter value before the wrap |
| shd_a_wr | input | 1 | Write strobe for the compare-A shadow |
| shd_b_wr | input | 1 | Write strobe for the compare-B shadow |
| shd_wdata | input | CNT_W | Shadow write data |
| act_cfg_a | input | 8 | Action table for output A |
| act_cfg_b | input | 8 | Action table for output B |
| pwm_a | output | 1 | Registered output A |
| pwm_b | output | 1 | Registered output B |
| cnt_q | output | CNT_W | Timebase counter |
| cmp_a_q | output | CNT_W | Working compare A |
| cmp_b_q | output | CNT_W | Working compare B |

## Verification
The bench uses the default CNT_W of 16 and PRE_SEL_W of 2, so each divider stage can be set from 1 to 8. Periods of 2 to 9 keep every wrap, shadow load and event collision within a few dozen cycles. Divider settings of 1, 4 and 8 test the cascade, including unequal stage settings. Compare values placed at zero, at the same value as each other and above the period drive the priority and no-match corner cases.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_INV  = 2'd3
  } aq_act_e;

  // event index: 0 zero, 1 period, 2 compare A, 3 compare B
  localparam int unsigned NUM_EV = 4;
  localparam int unsigned ACT_W  = 2 * NUM_EV;

  function automatic logic aq_apply(input logic cur, input aq_act_e act);
    logic res;
    case (act)
      ACT_LOW:  res = 1'b0;
      ACT_HIGH: res = 1'b1;
      ACT_INV:  res = ~cur;
      default:  res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/pwm_prescale_stage.sv
module pwm_prescale_stage #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = ((1 << SEL_W) - 1) > 0 ? ((1 << SEL_W) - 1) : 1;

  logic [DIV_W-1:0] div_q, div_d, lim;
  logic             at_lim;

  always_comb begin
    lim    = DIV_W'((1 << sel_i) - 1);
    at_lim = (div_q == lim);
    tick_o = en_i & at_lim;
    div_d  = div_q;
    if (clr_i)     div_d = '0;
    else if (en_i) div_d = at_lim ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_top;

  always_comb begin
    at_top = (cnt_q >= period_i);
    load_o = clr_i | (tick_i & at_top);
    cnt_d  = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (tick_i) cnt_d = at_top ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_cmp_shadow.sv
module pwm_cmp_shadow #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] act_o
);
  logic [CNT_W-1:0] shd_q, shd_d, act_q, act_d;

  always_comb begin
    shd_d = wr_i   ? wdata_i : shd_q;
    act_d = load_i ? shd_q   : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      shd_q <= shd_d;
      act_q <= act_d;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/pwm_aq_out.sv
module pwm_aq_out
  import pwm_aq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic [ACT_W-1:0]  cfg_i,
  output logic              pwm_o
);
  logic    out_q, out_d;
  aq_act_e win;

  always_comb begin
    win = ACT_NONE;
    // lowest index is applied last and therefore wins
    for (int i = NUM_EV - 1; i >= 0; i--) begin
      if (ev_i[i] && (cfg_i[2*i +: 2] != 2'd0)) win = aq_act_e'(cfg_i[2*i +: 2]);
    end
    out_d = aq_apply(out_q, win);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign pwm_o = out_q;
endmodule

// File: rtl/pwm_aq_channel.sv
module pwm_aq_channel
  import pwm_aq_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PRE_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cnt_en,
  input  logic                 cnt_clr,
  input  logic [PRE_SEL_W-1:0] pre_sel1,
  input  logic [PRE_SEL_W-1:0] pre_sel2,
  input  logic [CNT_W-1:0]     period,
  input  logic                 shd_a_wr,
  input  logic                 shd_b_wr,
  input  logic [CNT_W-1:0]     shd_wdata,
  input  logic [ACT_W-1:0]     act_cfg_a,
  input  logic [ACT_W-1:0]     act_cfg_b,
  output logic                 pwm_a,
  output logic                 pwm_b,
  output logic [CNT_W-1:0]     cnt_q,
  output logic [CNT_W-1:0]     cmp_a_q,
  output logic [CNT_W-1:0]     cmp_b_q
);
  localparam int unsigned NCH = 2;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic tick1, tick;

  pwm_prescale_stage #(.SEL_W(PRE_SEL_W)) u_pre1 (
    .clk(clk), .rst_n(rst_int_n), .clr_i(cnt_clr), .en_i(cnt_en),
    .sel_i(pre_sel1), .tick_o(tick1)
  );

  pwm_prescale_stage #(.SEL_W(PRE_SEL_W)) u_pre2 (
    .clk(clk), .rst_n(rst_int_n), .clr_i(cnt_clr), .en_i(tick1),
    .sel_i(pre_sel2), .tick_o(tick)
  );

  logic [CNT_W-1:0] cnt;
  logic             load;

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_int_n), .tick_i(tick), .clr_i(cnt_clr),
    .period_i(period), .cnt_o(cnt), .load_o(load)
  );

  logic [NCH-1:0]   shd_wr;
  logic [CNT_W-1:0] cmp_act [NCH];
  logic [ACT_W-1:0] act_cfg [NCH];
  logic [NCH-1:0]   cmp_hit;
  logic [NCH-1:0]   pwm_o;
  logic             ev_zero, ev_prd;
  logic [NUM_EV-1:0] ev;

  assign shd_wr     = {shd_b_wr, shd_a_wr};
  assign act_cfg[0] = act_cfg_a;
  assign act_cfg[1] = act_cfg_b;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_cmp
      pwm_cmp_shadow #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_int_n), .wr_i(shd_wr[c]), .wdata_i(shd_wdata),
        .load_i(load), .act_o(cmp_act[c])
      );
      assign cmp_hit[c] = tick & (cnt == cmp_act[c]) & (cmp_act[c] <= period);
    end
  endgenerate

  assign ev_zero = tick & (cnt == '0);
  assign ev_prd  = tick & (cnt == period);
  assign ev      = {cmp_hit[1], cmp_hit[0], ev_prd, ev_zero};

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_out
      pwm_aq_out u_aq (
        .clk(clk), .rst_n(rst_int_n), .ev_i(ev), .cfg_i(act_cfg[c]), .pwm_o(pwm_o[c])
      );
    end
  endgenerate

  assign pwm_a   = pwm_o[0];
  assign pwm_b   = pwm_o[1];
  assign cnt_q   = cnt;
  assign cmp_a_q = cmp_act[0];
  assign cmp_b_q = cmp_act[1];
endmodule

// File: rtl/pwm_aq_channel_chk.sv
module pwm_aq_channel_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             cnt_clr,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cmp_a_q,
  input logic [CNT_W-1:0] cmp_b_q,
  input logic             pwm_a,
  input logic             pwm_b
);
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1) || cnt_q == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !cnt_clr) |=> ($stable(cnt_q) && $stable(pwm_a) && $stable(pwm_b)));

  assert_out_on_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pwm_a) || !$stable(pwm_b)) |-> $past(cnt_en));

  assert_load_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cmp_a_q) || !$stable(cmp_b_q)) |-> (cnt_q == '0));

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_q == '0));
endmodule

bind pwm_aq_channel pwm_aq_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_clr(cnt_clr),
  .cnt_q(cnt_q), .cmp_a_q(cmp_a_q), .cmp_b_q(cmp_b_q),
  .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/pwm_aq_channel_tb.sv
module pwm_aq_channel_tb;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned PSW   = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cnt_en, cnt_clr;
  logic [PSW-1:0]   pre_sel1, pre_sel2;
  logic [CNT_W-1:0] period, shd_wdata;
  logic             shd_a_wr, shd_b_wr;
  logic [7:0]       act_cfg_a, act_cfg_b;
  logic             pwm_a, pwm_b;
  logic [CNT_W-1:0] cnt_q, cmp_a_q, cmp_b_q;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  pwm_aq_channel #(.CNT_W(CNT_W), .PRE_SEL_W(PSW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_clr(cnt_clr),
    .pre_sel1(pre_sel1), .pre_sel2(pre_sel2), .period(period),
    .shd_a_wr(shd_a_wr), .shd_b_wr(shd_b_wr), .shd_wdata(shd_wdata),
    .act_cfg_a(act_cfg_a), .act_cfg_b(act_cfg_b),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .cnt_q(cnt_q), .cmp_a_q(cmp_a_q), .cmp_b_q(cmp_b_q)
  );

  task automatic check(input string tag, input longint actv, input longint expv);
    total++;
    if (actv != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actv, expv, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cnt_en = 1'b0; cnt_clr = 1'b0;
    pre_sel1 = '0; pre_sel2 = '0; period = '0; shd_wdata = '0;
    shd_a_wr = 1'b0; shd_b_wr = 1'b0; act_cfg_a = '0; act_cfg_b = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // configure, load shadows through a clear, then start; next posedge is strobe k=1
  task automatic start(input int p, input int s1, input int s2, input int sa,
                       input int sb, input logic [7:0] aa, input logic [7:0] ab);
    do_reset();
    period = CNT_W'(p); pre_sel1 = PSW'(s1); pre_sel2 = PSW'(s2);
    act_cfg_a = aa; act_cfg_b = ab;
    shd_wdata = CNT_W'(sa); shd_a_wr = 1'b1;
    @(negedge clk);
    shd_a_wr = 1'b0; shd_wdata = CNT_W'(sb); shd_b_wr = 1'b1;
    @(negedge clk);
    shd_b_wr = 1'b0; cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0; cnt_en = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 cnt", cnt_q, 0);
    check("R1 pwm_a", pwm_a, 0);
    check("R1 pwm_b", pwm_b, 0);
    check("R1 cmp_a", cmp_a_q, 0);
    check("R1 cmp_b", cmp_b_q, 0);
  endtask

  task automatic run_count(input string tag, input int p, input int s1, input int s2, input int n);
    int d;
    d = 1 << (s1 + s2);
    start(p, s1, s2, 0, 0, 8'h00, 8'h00);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      check(tag, cnt_q, (k / d) % (p + 1));
    end
  endtask

  task automatic t_count();
    run_count("R2 count div1", 6, 0, 0, 20);
    run_count("R3 count div4", 3, 1, 1, 40);
    run_count("R3 count div8", 2, 1, 2, 50);
  endtask

  // R5/R6: A zero=high(2) cmpA=low(1) -> 0x12 ; B period=low(1) cmpB=high(2) -> 0x84
  task automatic t_shape();
    start(9, 0, 0, 3, 6, 8'h12, 8'h84);
    for (int k = 1; k <= 30; k++) begin
      int v;
      @(negedge clk);
      v = (k - 1) % 10;
      check("R6 R5 pwm_a edge aligned", pwm_a, (v < 3) ? 1 : 0);
      check("R6 R5 pwm_b late pulse", pwm_b, (v >= 6 && v <= 8) ? 1 : 0);
    end
  endtask

  // R7: B zero=invert(3) -> 0x03 ; A all none keeps 0
  task automatic t_toggle();
    start(4, 0, 0, 0, 0, 8'h00, 8'h03);
    for (int k = 1; k <= 25; k++) begin
      @(negedge clk);
      check("R7 pwm_b half rate", pwm_b, (((k - 1) / 5) % 2 == 0) ? 1 : 0);
      check("R5 pwm_a no action", pwm_a, 0);
    end
  endtask

  task automatic t_shadow();
    start(9, 0, 0, 3, 0, 8'h12, 8'h00);
    for (int k = 1; k <= 25; k++) begin
      int v;
      @(negedge clk);
      v = (k - 1) % 10;
      check("R4 cmp_a working", cmp_a_q, (k < 10) ? 3 : 7);
      check("R4 pwm_a width", pwm_a, (v < ((k <= 10) ? 3 : 7)) ? 1 : 0);
      if (k == 2) begin shd_wdata = CNT_W'(7); shd_a_wr = 1'b1; end
      if (k == 3) shd_a_wr = 1'b0;
    end
  endtask

  task automatic t_priority();
    // A cmpA=high 0x20 | cmpB=low 0x40 with both compares at 2: A wins
    start(5, 0, 0, 2, 2, 8'h60, 8'h00);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      check("R8 cmpA over cmpB", pwm_a, (k >= 3) ? 1 : 0);
    end
    // cmpA at 0: B zero=high beats cmpA=low; A zero=none lets cmpA=invert act
    start(5, 0, 0, 0, 0, 8'h30, 8'h12);
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      check("R8 zero over cmpA", pwm_b, 1);
      check("R8 none does not mask", pwm_a, (((k - 1) / 6) % 2 == 0) ? 1 : 0);
    end
  endtask

  task automatic t_overcmp();
    start(5, 0, 0, 7, 6, 8'h20, 8'h80);
    check("R9 cmp_a loaded", cmp_a_q, 7);
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      check("R9 pwm_a no match", pwm_a, 0);
      check("R9 pwm_b no match", pwm_b, 0);
    end
  endtask

  task automatic t_hold();
    start(9, 0, 0, 3, 0, 8'h12, 8'h00);
    repeat (2) @(negedge clk);
    check("R10 before hold", cnt_q, 2);
    cnt_en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R10 cnt held", cnt_q, 2);
      check("R10 pwm_a held", pwm_a, 1);
    end
    cnt_en = 1'b1;
    @(negedge clk);
    check("R10 resume", cnt_q, 3);
    @(negedge clk);
    check("R10 resume pwm_a", pwm_a, 0);
  endtask

  task automatic t_clear();
    start(9, 0, 0, 3, 0, 8'h00, 8'h00);
    repeat (4) @(negedge clk);
    shd_wdata = CNT_W'(5); shd_a_wr = 1'b1;
    @(negedge clk);
    shd_a_wr = 1'b0;
    check("R11 before clear", cnt_q, 5);
    check("R4 still old", cmp_a_q, 3);
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    check("R11 cnt cleared", cnt_q, 0);
    check("R11 shadow loaded", cmp_a_q, 5);
    @(negedge clk);
    check("R11 counting again", cnt_q, 1);
  endtask

  initial begin
    t_reset();
    t_count();
    t_shape();
    t_toggle();
    t_shadow();
    t_priority();
    t_overcmp();
    t_hold();
    t_clear();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule